// File: doc/BRIEF.md
# Non-volatile byte memory write sequencer

This block is the control front end of a small on-chip non-volatile byte memory. A CPU sees three byte-wide registers: a control register, an address register and a data register. A read strobe in the control register copies the addressed byte into the data register at once. A program operation needs a two-step unlock. Software first sets a master enable bit, which clears itself four cycles later. A program strobe takes effect only while that window is open.

Each program operation uses one of three modes: erase-and-write, erase-only or write-only. Each mode keeps the block busy for its own parameterized number of clock cycles. The new byte appears in the array when the busy period ends. While the block is busy, it refuses read strobes, address changes and mode changes. A level interrupt reports that the memory is ready. A stall output holds the CPU for a few cycles after a read or a program start. The storage is a behavioural byte array. Every byte of it holds 0xFF at power-up.

Top module: `nvm_write_ctrl`

## Requirements
- R1: Control register read layout: bits 7:6 read 0; bits 5:4 hold the mode field; bit 3 is the ready-interrupt enable; bit 2 is the master enable; bit 1 is the busy/program bit; bit 0 always reads 0. After reset, the control, address and data registers, busy, irq and stall all read 0.
- R2: Writing 1 to control bit 2 sets the master enable. It reads 1 for exactly four cycles after that write and then clears itself. Writing 0 to bit 2 does not clear it.
- R3: A control write with bit 1 set starts programming only when the master enable was 1 before that write, the block is idle and the written mode field (bits 5:4) is not 11. A strobe five or more cycles after the unlock write, or one with no unlock, leaves busy at 0 and the array unchanged.
- R4: Mode 00 (erase and write) keeps busy high for exactly T_ATOMIC cycles and stores the data register value.
- R5: Mode 01 (erase only) keeps busy high for exactly T_SINGLE cycles and stores 0xFF.
- R6: Mode 10 (write only) keeps busy high for exactly T_SINGLE cycles and stores the old byte ANDed with the data register.
- R7: A program strobe with mode 11 is ignored: busy stays 0 and the array is unchanged.
- R8: The programmed byte becomes visible in the cycle in which busy falls. Bit 1 of the control register tracks busy.
- R9: While busy: writes to the mode field are ignored, address register writes are ignored, and read strobes leave the data register unchanged and raise no stall.
- R10: Reset returns the mode field to 00 when the block is idle. If reset comes during programming, the mode field holds, busy keeps counting and the byte is still stored.
- R11: irq is 1 one cycle after the ready-interrupt enable and gie_i are both 1 while the block is idle. It is 0 whenever the block was busy in the previous cycle.
- R12: A read strobe (control bit 0 = 1, block idle, no program start in the same write) loads the data register with the addressed byte on the next cycle. It also raises stall for exactly 4 cycles.
- R13: A program start raises stall for exactly 2 cycles.
- R14: At power-up every byte of the array holds 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write value |
| ctrl_rdata | output | 8 | Control register read value |
| addr_we | input | 1 | Address register write strobe |
| addr_wdata | input | AW | Address register write value |
| addr_rdata | output | AW | Address register read value |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Data register write value |
| data_rdata | output | 8 | Data register read value |
| gie_i | input | 1 | Global interrupt enable from the CPU |
| busy_o | output | 1 | Programming in progress |
| irq_o | output | 1 | Ready interrupt request, level |
| stall_o | output | 1 | CPU stall request |

## Verification
Register writes, the master enable, busy and the data loaded by a read all show up on the first cycle after the write edge. irq follows its inputs one cycle later. The bench drives every input on a falling edge and samples on the next falling edge, so each read sees exactly the edges that have passed. Busy length and stall length are counted one sample per cycle, starting with the first sample after the strobe edge. Stored bytes are read back only once busy has dropped.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    MODE_ATOMIC = 2'b00,
    MODE_ERASE  = 2'b01,
    MODE_WRITE  = 2'b10,
    MODE_RSVD   = 2'b11
  } nvm_mode_e;

  localparam int BIT_RD    = 0;
  localparam int BIT_PROG  = 1;
  localparam int BIT_ARM   = 2;
  localparam int BIT_RIE   = 3;
  localparam int MODE_LSB  = 4;
  localparam int MODE_MSB  = 5;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  output logic open_o
);
  localparam int CW = $clog2(WINDOW + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (arm_i)          cnt_q <= CW'(WINDOW);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign open_o = (cnt_q != '0);
endmodule

// File: rtl/nvm_stall_gen.sv
module nvm_stall_gen #(
  parameter int RD_STALL = 4,
  parameter int PG_STALL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_i,
  input  logic pg_i,
  output logic stall_o
);
  localparam int SMAX = (RD_STALL > PG_STALL) ? RD_STALL : PG_STALL;
  localparam int CW   = $clog2(SMAX + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (rd_i)         cnt_q <= CW'(RD_STALL);
    else if (pg_i)         cnt_q <= CW'(PG_STALL);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign stall_o = (cnt_q != '0);
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer
  import nvm_pkg::*;
#(
  parameter int T_ATOMIC = 34,
  parameter int T_SINGLE = 18,
  parameter int AW       = 6,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          start_i,
  input  nvm_mode_e     mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wval_i,
  output logic          busy_o,
  output logic          commit_o,
  output logic [AW-1:0] caddr_o,
  output logic [DW-1:0] cval_o
);
  localparam int TMAX = (T_ATOMIC > T_SINGLE) ? T_ATOMIC : T_SINGLE;
  localparam int CW   = $clog2(TMAX + 1);

  // Power-up values only: reset must not abort an operation in flight.
  logic [CW-1:0] cnt_q  = '0;
  logic [AW-1:0] addr_q = '0;
  logic [DW-1:0] val_q  = '0;
  logic [CW-1:0] dur;

  always_comb begin
    dur = (mode_i == MODE_ATOMIC) ? CW'(T_ATOMIC) : CW'(T_SINGLE);
  end

  always_ff @(posedge clk) begin
    if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (start_i) begin
      cnt_q  <= dur;
      addr_q <= addr_i;
      val_q  <= wval_i;
    end
  end

  assign busy_o   = (cnt_q != '0);
  assign commit_o = (cnt_q == CW'(1));
  assign caddr_o  = addr_q;
  assign cval_o   = val_q;
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl
  import nvm_pkg::*;
#(
  parameter int AW            = 6,
  parameter int T_ATOMIC      = 34,
  parameter int T_SINGLE      = 18,
  parameter int UNLOCK_CYCLES = 4,
  parameter int RD_STALL      = 4,
  parameter int PG_STALL      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic [7:0]    ctrl_wdata,
  output logic [7:0]    ctrl_rdata,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_wdata,
  output logic [AW-1:0] addr_rdata,
  input  logic          data_we,
  input  logic [7:0]    data_wdata,
  output logic [7:0]    data_rdata,
  input  logic          gie_i,
  output logic          busy_o,
  output logic          irq_o,
  output logic          stall_o
);
  localparam int DW = 8;

  nvm_mode_e     mode_q;
  nvm_mode_e     wr_mode;
  logic          rie_q, irq_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          busy, arm_open, start, rd_go, arm;
  logic          commit;
  logic [AW-1:0] caddr;
  logic [DW-1:0] cval, rdata, wval;

  assign wr_mode = nvm_mode_e'(ctrl_wdata[MODE_MSB:MODE_LSB]);
  assign arm     = ctrl_we && ctrl_wdata[BIT_ARM] && !rst;
  assign start   = ctrl_we && ctrl_wdata[BIT_PROG] && arm_open && !busy
                   && (wr_mode != MODE_RSVD) && !rst;
  assign rd_go   = ctrl_we && ctrl_wdata[BIT_RD] && !busy && !start && !rst;

  always_comb begin
    unique case (wr_mode)
      MODE_ATOMIC: wval = data_q;
      MODE_ERASE:  wval = '1;
      MODE_WRITE:  wval = rdata & data_q;
      default:     wval = data_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (!busy) mode_q <= MODE_ATOMIC;
    end else if (ctrl_we && !busy) begin
      mode_q <= wr_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rie_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_we)            rie_q  <= ctrl_wdata[BIT_RIE];
      if (addr_we && !busy)   addr_q <= addr_wdata;
      if (rd_go)              data_q <= rdata;
      else if (data_we)       data_q <= data_wdata;
      irq_q <= rie_q && gie_i && !busy;
    end
  end

  nvm_unlock #(.WINDOW(UNLOCK_CYCLES)) u_unlock (
    .clk(clk), .rst(rst), .arm_i(arm), .open_o(arm_open)
  );

  nvm_prog_timer #(.T_ATOMIC(T_ATOMIC), .T_SINGLE(T_SINGLE), .AW(AW), .DW(DW)) u_timer (
    .clk(clk), .start_i(start), .mode_i(wr_mode), .addr_i(addr_q), .wval_i(wval),
    .busy_o(busy), .commit_o(commit), .caddr_o(caddr), .cval_o(cval)
  );

  nvm_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .we_i(commit), .waddr_i(caddr), .wdata_i(cval),
    .raddr_i(addr_q), .rdata_o(rdata)
  );

  nvm_stall_gen #(.RD_STALL(RD_STALL), .PG_STALL(PG_STALL)) u_stall (
    .clk(clk), .rst(rst), .rd_i(rd_go), .pg_i(start), .stall_o(stall_o)
  );

  assign ctrl_rdata = {2'b00, mode_q, rie_q, arm_open, busy, 1'b0};
  assign addr_rdata = addr_q;
  assign data_rdata = data_q;
  assign busy_o     = busy;
  assign irq_o      = irq_q;
endmodule

// File: rtl/nvm_write_ctrl_chk.sv
module nvm_write_ctrl_chk #(
  parameter int AW     = 6,
  parameter int WINDOW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          ctrl_we,
  input logic [7:0]    ctrl_wdata,
  input logic          arm_open,
  input logic          busy,
  input logic [1:0]    mode,
  input logic [AW-1:0] addr,
  input logic          irq,
  input logic          stall
);
  localparam int RW = $clog2(WINDOW + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)                         run_q <= '0;
    else if (ctrl_we && ctrl_wdata[2]) run_q <= '0;
    else if (arm_open && run_q != '1)  run_q <= run_q + 1'b1;
    else if (!arm_open)              run_q <= '0;
  end

  // R2: master enable never outlives its window
  a_r2_window_len: assert property (@(posedge clk) disable iff (rst)
    arm_open |-> (run_q < RW'(WINDOW)));

  // R3: busy only rises after a strobe inside the unlock window
  a_r3_start_needs_unlock: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ctrl_we && ctrl_wdata[1] && arm_open));

  // R9: mode and address frozen while busy
  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mode));
  a_r9_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(rst)) |-> $stable(addr));

  // R11: no ready interrupt while programming
  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !irq);

  // R12: accepted read stalls the CPU
  a_r12_read_stall: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && ctrl_wdata[0] && !ctrl_wdata[1] && !busy) |=> stall);

  // R13: program start stalls the CPU
  a_r13_start_stall: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> stall);
endmodule

bind nvm_write_ctrl nvm_write_ctrl_chk #(.AW(AW), .WINDOW(UNLOCK_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
  .arm_open(arm_open), .busy(busy), .mode(mode_q), .addr(addr_q),
  .irq(irq_q), .stall(stall_o)
);

// File: tb/nvm_write_ctrl_tb.sv
module nvm_write_ctrl_tb;
  localparam int AW = 6;
  localparam int TA = 34;
  localparam int TS = 18;

  logic clk = 1'b0, rst = 1'b1;
  logic ctrl_we = 0, addr_we = 0, data_we = 0, gie = 0;
  logic [7:0] ctrl_wdata = 0, data_wdata = 0;
  logic [AW-1:0] addr_wdata = 0;
  logic [7:0] ctrl_rdata, data_rdata;
  logic [AW-1:0] addr_rdata;
  logic busy, irq, stall;
  logic rie = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nvm_write_ctrl #(.AW(AW), .T_ATOMIC(TA), .T_SINGLE(TS)) u_dut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .addr_we(addr_we), .addr_wdata(addr_wdata), .addr_rdata(addr_rdata),
    .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
    .gie_i(gie), .busy_o(busy), .irq_o(irq), .stall_o(stall)
  );

  // {mode, addr, data, expected stored byte}
  localparam logic [23:0] VEC [6] = '{
    {2'b00, 6'd3,  8'h5A, 8'h5A},
    {2'b10, 6'd3,  8'h0F, 8'h0A},
    {2'b01, 6'd3,  8'h00, 8'hFF},
    {2'b10, 6'd7,  8'h3C, 8'h3C},
    {2'b00, 6'd63, 8'h00, 8'h00},
    {2'b11, 6'd7,  8'h00, 8'h3C}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctrl_wr(input logic [1:0] m, input logic arm, input logic prog, input logic rd);
    @(negedge clk);
    ctrl_we = 1; ctrl_wdata = {2'b00, m, rie, arm, prog, rd};
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic addr_wr(input logic [AW-1:0] a);
    @(negedge clk); addr_we = 1; addr_wdata = a;
    @(negedge clk); addr_we = 0;
  endtask

  task automatic data_wr(input logic [7:0] d);
    @(negedge clk); data_we = 1; data_wdata = d;
    @(negedge clk); data_we = 0;
  endtask

  task automatic read_at(input logic [AW-1:0] a, output logic [7:0] d);
    addr_wr(a);
    ctrl_wr(2'b00, 0, 0, 1);
    d = data_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] d;
    int nb, ns;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset ctrl", ctrl_rdata, 8'h00);
    check("R1 reset addr", addr_rdata, 0);
    check("R1 reset data", data_rdata, 0);
    check("R1 reset busy/irq/stall", {busy, irq, stall}, 3'b000);

    // R14 erased state, R12 read data and stall
    addr_wr(6'd40);
    ctrl_wr(2'b00, 0, 0, 1);
    check("R14 erased byte", data_rdata, 8'hFF);
    check("R1 read bit reads 0", ctrl_rdata[0], 0);
    ns = 0;
    for (int i = 0; i < 6; i++) begin if (stall) ns++; @(negedge clk); end
    check("R12 read stall cycles", ns, 4);

    // R2 window length
    ctrl_wr(2'b00, 1, 0, 0);
    nb = 0;
    for (int i = 0; i < 6; i++) begin if (ctrl_rdata[2]) nb++; @(negedge clk); end
    check("R2 master enable cycles", nb, 4);

    // Vector table: R4 R5 R6 R7 R8 R13
    for (int v = 0; v < 6; v++) begin
      logic [1:0] m;
      int exp_t;
      m = VEC[v][23:22];
      exp_t = (m == 2'b00) ? TA : (m == 2'b11) ? 0 : TS;
      addr_wr(VEC[v][21:16]);
      data_wr(VEC[v][15:8]);
      ctrl_wr(m, 1, 0, 0);
      ctrl_wr(m, 0, 1, 0);
      nb = 0; ns = 0;
      for (int i = 0; i < 100 && busy; i++) begin
        nb++; if (stall) ns++;
        if (ctrl_rdata[1] !== 1'b1) check("R8 ctrl busy bit", ctrl_rdata[1], 1);
        @(negedge clk);
      end
      check($sformatf("R4/R5/R6/R7 busy length vec%0d", v), nb, exp_t);
      if (exp_t > 0) check("R13 start stall cycles", ns, 2);
      check("R8 ctrl busy bit clear", ctrl_rdata[1], 0);
      read_at(VEC[v][21:16], d);
      check($sformatf("R4/R5/R6/R7 stored byte vec%0d", v), d, VEC[v][7:0]);
    end

    // R3: strobe without unlock, and strobe too late
    addr_wr(6'd20); data_wr(8'h11);
    ctrl_wr(2'b00, 0, 1, 0);
    check("R3 strobe without unlock", busy, 0);
    ctrl_wr(2'b00, 1, 0, 0);
    repeat (3) @(negedge clk);
    ctrl_wr(2'b00, 0, 1, 0);
    check("R3 strobe 5 cycles after unlock", busy, 0);
    read_at(6'd20, d);
    check("R3 array unchanged", d, 8'hFF);
    // last cycle of the window still works
    data_wr(8'h11);
    ctrl_wr(2'b00, 1, 0, 0);
    repeat (2) @(negedge clk);
    ctrl_wr(2'b00, 0, 1, 0);
    check("R3 strobe 4 cycles after unlock", busy, 1);

    // R9 lockouts while busy
    addr_wr(6'd2);
    check("R9 address write ignored", addr_rdata, 6'd20);
    ctrl_wr(2'b01, 0, 0, 1);
    check("R9 mode write ignored", ctrl_rdata[5:4], 2'b00);
    check("R9 read ignored data", data_rdata, 8'h11);
    check("R9 read ignored stall", stall, 0);
    @(negedge clk);
    check("R11 irq low while busy", irq, 0);
    wait_idle();
    read_at(6'd20, d);
    check("R8 atomic result after busy", d, 8'h11);

    // R10 reset when idle clears the mode field
    ctrl_wr(2'b01, 0, 0, 0);
    check("R1 mode readback", ctrl_rdata[5:4], 2'b01);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    check("R10 idle reset mode", ctrl_rdata, 8'h00);

    // R10 reset during programming
    addr_wr(6'd5); data_wr(8'h21);
    ctrl_wr(2'b10, 1, 0, 0);
    ctrl_wr(2'b10, 0, 1, 0);
    repeat (3) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    check("R10 busy survives reset", busy, 1);
    check("R10 mode held", ctrl_rdata[5:4], 2'b10);
    check("R10 addr reset", addr_rdata, 0);
    wait_idle();
    read_at(6'd5, d);
    check("R10 byte stored after reset", d, 8'h21);

    // R11 interrupt
    rie = 1; gie = 1;
    ctrl_wr(2'b00, 0, 0, 0);
    @(negedge clk);
    check("R11 irq when ready", irq, 1);
    gie = 0;
    @(negedge clk);
    check("R11 irq off when gie low", irq, 0);
    gie = 1;
    ctrl_wr(2'b01, 1, 0, 0);
    ctrl_wr(2'b01, 0, 1, 0);
    @(negedge clk);
    check("R11 irq low while busy", irq, 0);
    wait_idle();
    @(negedge clk);
    check("R11 irq back when idle", irq, 1);

    summary();
  end
endmodule